// File: doc/BRIEF.md
# Lockable Countdown Watchdog

This block is a down-counter behind a small word-addressed register window. It serves either as a periodic or one-shot interrupt timer, or as a system watchdog. A prescaler slows the count. In timer mode, reaching zero raises an interrupt status flag. In watchdog mode, reaching zero instead raises a single-cycle reset request toward the chip's reset network and records that a watchdog reset was issued.

Software can switch watchdog mode on with any ordinary control write. It cannot switch it off that way. The mode bit is cleared only when two fixed unlock words arrive back to back at a dedicated unlock register, so a runaway program cannot easily disable its own watchdog. The register port is a plain single-cycle write strobe with a combinational read. There is no back-pressure: every write is taken in the cycle it is presented.

Top module: `wdt_top`

## Requirements
- R1: After power-on reset (rst_n low) every register reads 0, and irq and wdog_rst_req are low.
- R2: The window has six word registers: 0x00 reload value, 0x04 live count, 0x08 control, 0x0C event status, 0x10 reset-issued flag and 0x14 unlock. A write to 0x00 sets both the reload value and the live count. Writes to 0x04 are ignored. 0x14 reads as 0.
- R3: With control bit 0 (run) set, the count falls by one every P+1 clocks, where P is control bits 15:8. The first step falls on the (P+1)-th clock edge after the enabling write. With run clear, the count holds.
- R4: When the count steps from 1 to 0, it is refilled from the reload value if control bit 1 (auto-reload) is set, and otherwise stays at 0.
- R5: In timer mode, the step to zero sets status bit 0. irq equals status bit 0 AND control bit 2 (interrupt enable). Writing 1 to status bit 0 clears it and writing 0 does nothing. The timer-mode event does not touch wdog_rst_req.
- R6: Control bit 3 (watchdog mode) becomes 1 when a control write carries a 1 there. A control write with 0 there leaves it unchanged. The other control bits take the written value.
- R7: In watchdog mode, the step to zero drives wdog_rst_req high for the one cycle after that edge and sets reset-issued bit 0. It does not set the status bit.
- R8: Reset-issued bit 0 is cleared only by writing 1 to it or by power-on reset. Writing 0 to it, or completing the unlock sequence, leaves it set.
- R9: Writing 0x12345678 and then 0x87654321 to the unlock register, as two consecutive writes, clears control bit 3 and keeps all other control bits. Repeating the first word re-arms the sequence.
- R10: Any other write in between, including a wrong value to the unlock register or a write to another register, cancels the sequence. The second word alone has no effect. Reads do not cancel it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| wr_en | input | 1 | Write strobe, one write per high cycle |
| addr | input | 5 | Byte offset of the addressed register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| irq | output | 1 | Timer interrupt |
| wdog_rst_req | output | 1 | One-cycle system reset request |

## Verification
Register writes take effect at the edge that samples the strobe, and reads are combinational, so the bench samples every read-back at the falling edge after the write. When run is enabled by the write at edge 0, count steps fall at edges k·(P+1). The status flag, irq and the reset-issued flag therefore change exactly at edge L·(P+1) for a load of L, and wdog_rst_req is high only in the cycle after that edge. The bench sweeps L from 1 to 4 and P from 0 to 3. For each pair it samples once just before and once just after the due edge, checking the count, the flags and the reset request there.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned DW   = 32;
  localparam int unsigned AW   = 5;
  localparam int unsigned PS_W = 8;

  localparam logic [AW-1:0] A_LOAD  = 5'h00;
  localparam logic [AW-1:0] A_COUNT = 5'h04;
  localparam logic [AW-1:0] A_CTRL  = 5'h08;
  localparam logic [AW-1:0] A_STAT  = 5'h0C;
  localparam logic [AW-1:0] A_RSENT = 5'h10;
  localparam logic [AW-1:0] A_UNLK  = 5'h14;

  typedef struct packed {
    logic [PS_W-1:0] presc;
    logic            wd;
    logic            irq_en;
    logic            reload;
    logic            run;
  } ctrl_t;
endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int unsigned PS_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [PS_W-1:0] div,
  output logic            tick
);
  logic [PS_W-1:0] pc;

  assign tick = run && (pc >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            pc <= '0;
    else if (!run || tick) pc <= '0;
    else                   pc <= pc + 1'b1;
  end

  // R3: with a steady nonzero divider, two ticks never fall on adjacent edges
  a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tick) && $past(run) && run && div != '0 && $stable(div)) |-> !tick);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             reload_en,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             ld_we,
  input  logic [CNT_W-1:0] ld_data,
  output logic [CNT_W-1:0] cnt,
  output logic             zero_evt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign zero_evt = tick && !ld_we && (cnt == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (ld_we)
      cnt <= ld_data;
    else if (tick) begin
      if (cnt > ONE)   cnt <= cnt - ONE;
      else if (reload_en) cnt <= reload_val;
      else             cnt <= '0;
    end
  end

  // R3: an ordinary tick lowers the count by exactly one
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ld_we && cnt > ONE) |=> cnt == $past(cnt) - ONE);
  // R4: without auto-reload, a zero count stays at zero
  a_r4_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload_en && !ld_we && cnt == '0) |=> cnt == '0);
endmodule

// File: rtl/wdt_unlock.sv
module wdt_unlock #(
  parameter int unsigned DW      = 32,
  parameter logic [DW-1:0] KEY_A = 32'h1234_5678,
  parameter logic [DW-1:0] KEY_B = 32'h8765_4321
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          hit,
  input  logic [DW-1:0] wdata,
  output logic          unlock
);
  logic armed;

  assign unlock = wr_en && armed && hit && (wdata == KEY_B);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     armed <= 1'b0;
    else if (wr_en) armed <= hit && (wdata == KEY_A);
  end

  // R10: the sequence stays armed across cycles without writes
  a_r10_armed_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(armed) && !$past(wr_en)) |-> armed);
  // R10: being armed always follows a write
  a_r10_armed_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(wr_en));
endmodule

// File: rtl/wdt_top.sv
module wdt_top #(
  parameter int unsigned CNT_W         = 32,
  parameter logic [31:0] UNLOCK_WORD_A = 32'h1234_5678,
  parameter logic [31:0] UNLOCK_WORD_B = 32'h8765_4321
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [4:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq,
  output logic        wdog_rst_req
);
  import wdt_pkg::*;

  ctrl_t            ctrl;
  logic [CNT_W-1:0] load_reg;
  logic [CNT_W-1:0] cnt;
  logic             irq_st;
  logic             rst_sent;
  logic             tick, zero_evt, unlock;
  logic             we_load, we_ctrl, we_stat, we_rs;
  logic [DW-1:0]    cnt_ext, load_ext;

  assign we_load = wr_en && (addr == A_LOAD);
  assign we_ctrl = wr_en && (addr == A_CTRL);
  assign we_stat = wr_en && (addr == A_STAT);
  assign we_rs   = wr_en && (addr == A_RSENT);

  wdt_prescale #(.PS_W(PS_W)) u_ps (
    .clk(clk), .rst_n(rst_n), .run(ctrl.run), .div(ctrl.presc), .tick(tick)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reload_en(ctrl.reload),
    .reload_val(load_reg), .ld_we(we_load), .ld_data(wdata[CNT_W-1:0]),
    .cnt(cnt), .zero_evt(zero_evt)
  );

  wdt_unlock #(.DW(DW), .KEY_A(UNLOCK_WORD_A), .KEY_B(UNLOCK_WORD_B)) u_ul (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .hit(addr == A_UNLK),
    .wdata(wdata), .unlock(unlock)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl     <= '0;
      load_reg <= '0;
    end else begin
      if (we_load) load_reg <= wdata[CNT_W-1:0];
      if (we_ctrl) begin
        ctrl.run    <= wdata[0];
        ctrl.reload <= wdata[1];
        ctrl.irq_en <= wdata[2];
        ctrl.wd     <= ctrl.wd | wdata[3];
        ctrl.presc  <= wdata[8 +: PS_W];
      end else if (unlock) begin
        ctrl.wd <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_st       <= 1'b0;
      rst_sent     <= 1'b0;
      wdog_rst_req <= 1'b0;
    end else begin
      if (zero_evt && !ctrl.wd)      irq_st <= 1'b1;
      else if (we_stat && wdata[0])  irq_st <= 1'b0;
      if (zero_evt && ctrl.wd)       rst_sent <= 1'b1;
      else if (we_rs && wdata[0])    rst_sent <= 1'b0;
      wdog_rst_req <= zero_evt && ctrl.wd;
    end
  end

  assign irq = irq_st && ctrl.irq_en;

  always_comb begin
    cnt_ext  = '0;
    cnt_ext[CNT_W-1:0] = cnt;
    load_ext = '0;
    load_ext[CNT_W-1:0] = load_reg;
    unique case (addr)
      A_LOAD:  rdata = load_ext;
      A_COUNT: rdata = cnt_ext;
      A_CTRL:  rdata = {16'h0, ctrl.presc, 4'h0, ctrl.wd, ctrl.irq_en, ctrl.reload, ctrl.run};
      A_STAT:  rdata = {31'h0, irq_st};
      A_RSENT: rdata = {31'h0, rst_sent};
      default: rdata = '0;
    endcase
  end

  // R6: watchdog mode only falls through a completed unlock
  a_r6_set_only: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctrl.wd) && !$past(unlock)) |-> ctrl.wd);
  // R9: a completed unlock leaves watchdog mode off
  a_r9_unlock_clears: assert property (@(posedge clk) disable iff (!rst_n)
    unlock |=> !ctrl.wd);
  // R7: every reset request is recorded in the reset-issued flag
  a_r7_req_recorded: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst_req |-> rst_sent);
  // R7: the status flag is never raised by a watchdog-mode event
  a_r7_no_stat_in_wd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_st) |-> !$past(ctrl.wd));
  // R8: the reset-issued flag is sticky until a write of 1
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_sent) && !($past(we_rs) && $past(wdata[0]))) |-> rst_sent);
endmodule

// File: tb/sim_wdt_top.sv
module sim_wdt_top;
  localparam logic [4:0] A_LOAD = 5'h00, A_COUNT = 5'h04, A_CTRL = 5'h08,
                         A_STAT = 5'h0C, A_RSENT = 5'h10, A_UNLK = 5'h14;
  localparam logic [31:0] KA = 32'h1234_5678, KB = 32'h8765_4321;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, wdog_rst_req;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wdt_top u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq), .wdog_rst_req(wdog_rst_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic chk_reg(input string req, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk_reg("R1 load", A_LOAD, 0);
    chk_reg("R1 count", A_COUNT, 0);
    chk_reg("R1 ctrl", A_CTRL, 0);
    chk_reg("R1 stat", A_STAT, 0);
    chk_reg("R1 rsent", A_RSENT, 0);
    chk("R1 irq", irq, 0);
    chk("R1 rst_req", wdog_rst_req, 0);

    // R2 load writes count; count writes ignored; unlock reads 0
    wr(A_LOAD, 32'h1234);
    chk_reg("R2 load", A_LOAD, 32'h1234);
    chk_reg("R2 count", A_COUNT, 32'h1234);
    wr(A_COUNT, 32'h55);
    chk_reg("R2 count write ignored", A_COUNT, 32'h1234);
    chk_reg("R2 unlock reads 0", A_UNLK, 0);

    // R3 holds while stopped
    repeat (5) @(negedge clk);
    chk_reg("R3 hold stopped", A_COUNT, 32'h1234);

    // R3/R5 sweep over load and prescale
    for (int p = 0; p < 4; p++) begin
      for (int l = 1; l <= 4; l++) begin
        wr(A_CTRL, 0);
        wr(A_STAT, 1);
        wr(A_LOAD, l);
        wr(A_CTRL, (p << 8) | 32'h5);
        repeat (l * (p + 1) - 1) @(negedge clk);
        chk_reg("R3 count before zero", A_COUNT, 1);
        chk_reg("R5 stat before zero", A_STAT, 0);
        chk("R5 irq before zero", irq, 0);
        @(negedge clk);
        chk_reg("R4 count at zero", A_COUNT, 0);
        chk_reg("R5 stat at zero", A_STAT, 1);
        chk("R5 irq at zero", irq, 1);
        chk("R5 no rst_req in timer mode", wdog_rst_req, 0);
      end
    end
    chk_reg("R5 rsent untouched by timer", A_RSENT, 0);

    // R5 write-one-to-clear and enable gating
    wr(A_STAT, 0);
    chk_reg("R5 write 0 keeps stat", A_STAT, 1);
    wr(A_CTRL, 32'h0301);
    chk("R5 irq gated by enable", irq, 0);
    chk_reg("R5 stat still set", A_STAT, 1);
    wr(A_STAT, 1);
    chk_reg("R5 write 1 clears stat", A_STAT, 0);

    // R4 auto-reload
    wr(A_CTRL, 0);
    wr(A_LOAD, 2);
    wr(A_CTRL, 32'h3);
    @(negedge clk); chk_reg("R4 reload step1", A_COUNT, 1);
    @(negedge clk); chk_reg("R4 reloaded", A_COUNT, 2);
    chk_reg("R4 event on reload", A_STAT, 1);
    @(negedge clk); chk_reg("R4 reload step3", A_COUNT, 1);
    @(negedge clk); chk_reg("R4 reloaded again", A_COUNT, 2);
    wr(A_CTRL, 0);
    wr(A_STAT, 1);

    // R7 watchdog-mode expiry
    wr(A_LOAD, 3);
    wr(A_CTRL, 32'h9);
    @(negedge clk); chk("R7 no req edge1", wdog_rst_req, 0);
    @(negedge clk); chk("R7 no req edge2", wdog_rst_req, 0);
    @(negedge clk); chk("R7 req after edge3", wdog_rst_req, 1);
    chk_reg("R7 rsent set", A_RSENT, 1);
    chk_reg("R7 stat not set", A_STAT, 0);
    @(negedge clk); chk("R7 req one cycle", wdog_rst_req, 0);

    // R6 set-only mode bit
    wr(A_CTRL, 0);
    chk_reg("R6 wd survives write of 0", A_CTRL, 32'h8);
    wr(A_CTRL, 32'h306);
    chk_reg("R6 other bits written", A_CTRL, 32'h30E);

    // R8 write 0 keeps flag
    wr(A_RSENT, 0);
    chk_reg("R8 write 0 keeps rsent", A_RSENT, 1);

    // R10 broken sequences
    wr(A_UNLK, KA); wr(A_LOAD, 7); wr(A_UNLK, KB);
    chk_reg("R10 other write cancels", A_CTRL, 32'h30E);
    wr(A_UNLK, KA); wr(A_UNLK, 32'hDEAD); wr(A_UNLK, KB);
    chk_reg("R10 wrong word cancels", A_CTRL, 32'h30E);
    wr(A_UNLK, KB);
    chk_reg("R10 second word alone", A_CTRL, 32'h30E);

    // R9 good sequence with a read in between
    wr(A_UNLK, KA);
    rd(A_CTRL, v);
    wr(A_UNLK, KB);
    chk_reg("R9 unlock clears wd only", A_CTRL, 32'h306);
    chk_reg("R8 rsent survives unlock", A_RSENT, 1);
    wr(A_RSENT, 1);
    chk_reg("R8 write 1 clears rsent", A_RSENT, 0);

    // R9 repeated first word re-arms
    wr(A_CTRL, 32'h8);
    chk_reg("R6 wd set again", A_CTRL, 32'h8);
    wr(A_UNLK, KA); wr(A_UNLK, KA); wr(A_UNLK, KB);
    chk_reg("R9 rearm then unlock", A_CTRL, 0);

    summary();
  end
endmodule